// File: doc/BRIEF.md
# Memory Event Performance Counter Bank

This block holds six performance counters for a memory controller. Each counter has its own event code and a seven-bit source mask, both set by software. Every clock, the block takes in three groups of event inputs:

- strobes for the source-tagged events, each with a three-bit source tag;
- strobes for the plain single-count events;
- multi-bit occupancy or size values.

It also takes a tick that marks each cycle of the half-data-rate memory clock. Software reads and writes the counters, their configuration, their overflow flags and a global enable through a plain register port.

A small decoder turns each event code into one of five named update classes:

- `CLS_NONE`: hold the value.
- `CLS_FILT`: add one if the selected strobe fires and its source tag has its mask bit set.
- `CLS_UNF`: add one per strobe, ignoring the mask.
- `CLS_ACC`: add the selected lane value every cycle.
- `CLS_CYC`: add one per memory-clock tick.

The class is a pure function of the code, so it has no transitions of its own. It changes only when software rewrites the code, and the new class governs updates from the cycle after the write.

Top module: `memevt_ctr_bank`

## Requirements
- R1: Six counters update independently. Each one follows only its own event code and mask.
- R2: Event code 0 leaves the counter unchanged.
- R3: Codes 1 to 7 select strobe bit (code-1) of `fevt_pulse`. That event's source tag is bits [3k+2:3k] of `fevt_src`, where k = code-1. The counter adds one only when the strobe is high and the mask bit indexed by the tag is set. Tag 7 never counts.
- R4: The following codes add one when their bit of `uevt_pulse` is high, whatever the mask holds:

  | Code | `uevt_pulse` bit |
  |------|------------------|
  | 16   | 0 |
  | 17   | 1 |
  | 18   | 2 |
  | 32   | 3 |
  | 48   | 4 |
  | 64   | 5 |
  | 96   | 6 |
  | 97   | 7 |

- R5: Codes 80, 81, 82, 83, 112 and 113 select `acc_val` lanes 0 to 5 respectively. Lane j is bits [8j+7:8j]. The counter adds that unsigned lane value on every enabled cycle.
- R6: Code 255 adds one on each cycle in which `dram_tick` is high, with no filtering.
- R7: Any code not listed in R2 to R6 behaves like code 0.
- R8: Counters are 32 bits and wrap modulo 2^32. A wrap sets that counter's overflow flag. The flag stays set until software writes the counter.
- R9: A software write to a counter replaces the value and clears its overflow flag, taking priority over any increment in the same cycle.
- R10: While the global enable is 0, all counters hold, but software writes still take effect. Reset clears every counter, flag, configuration and the enable.
- R11: Register map:
  - For counter n (0 to 5), the base address is 4n. Offset 0 is the count. Offset 1 is the configuration: code in bits 7:0, mask in bits 14:8. Offset 2 is the overflow flag in bit 0.
  - Address 24 bit 0 is the global enable.
  - Reads of all other addresses return 0.
  - Reads are combinational.
  - A configuration write governs updates from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| fevt_pulse | input | 7 | Strobes of source-tagged events (codes 1 to 7) |
| fevt_src | input | 21 | Three-bit source tag per tagged event |
| uevt_pulse | input | 8 | Strobes of plain count events |
| acc_val | input | 48 | Six 8-bit occupancy or size lanes |
| dram_tick | input | 1 | One per half-data-rate memory clock cycle |

## Verification
The bench targets the following corner cases:

- **Mask handling.** It checks tags masked out, tag 7, and a wrong strobe for the selected code. A design that ignored the mask, or indexed it out of range, would count these.
- **Wrap and priority.** It drives a counter across the 2^32 boundary, then ticks and writes in the same cycle. A design that cleared the flag on the next increment, or let the adder beat the write, would show a wrong flag or value.
- **Hold codes and undefined codes.** It drives every input with code 0 and with an undefined code. A decoder that fell through into a counting class would move the counter.
- **Enable and configuration timing.** It checks the disabled state and a configuration write made in the same cycle as a tick. A frozen bank that dropped writes, or a configuration that acted one cycle early, would show up here.

// File: rtl/memevt_pkg.sv
package memevt_pkg;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_FILT,
        CLS_UNF,
        CLS_ACC,
        CLS_CYC
    } evt_cls_e;

    localparam int N_FILT = 7;
    localparam int N_UNF  = 8;
    localparam int N_ACC  = 6;
    localparam int LANE_W = 3;
    localparam int CODE_W = 8;

endpackage

// File: rtl/memevt_decode.sv
module memevt_decode
    import memevt_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output evt_cls_e          cls,
    output logic [LANE_W-1:0] lane
);

    always_comb begin
        cls  = CLS_NONE;
        lane = '0;
        unique case (code)
            8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7: begin
                cls  = CLS_FILT;
                lane = code[LANE_W-1:0] - 3'd1;
            end
            8'd16:  begin cls = CLS_UNF; lane = 3'd0; end
            8'd17:  begin cls = CLS_UNF; lane = 3'd1; end
            8'd18:  begin cls = CLS_UNF; lane = 3'd2; end
            8'd32:  begin cls = CLS_UNF; lane = 3'd3; end
            8'd48:  begin cls = CLS_UNF; lane = 3'd4; end
            8'd64:  begin cls = CLS_UNF; lane = 3'd5; end
            8'd96:  begin cls = CLS_UNF; lane = 3'd6; end
            8'd97:  begin cls = CLS_UNF; lane = 3'd7; end
            8'd80:  begin cls = CLS_ACC; lane = 3'd0; end
            8'd81:  begin cls = CLS_ACC; lane = 3'd1; end
            8'd82:  begin cls = CLS_ACC; lane = 3'd2; end
            8'd83:  begin cls = CLS_ACC; lane = 3'd3; end
            8'd112: begin cls = CLS_ACC; lane = 3'd4; end
            8'd113: begin cls = CLS_ACC; lane = 3'd5; end
            8'd255: begin cls = CLS_CYC; lane = 3'd0; end
            default: begin cls = CLS_NONE; lane = 3'd0; end // R2, R7
        endcase
    end

    // Filtered lanes stay inside the seven tagged strobes (R3)
    always_comb begin
        if (cls == CLS_FILT)
            assert_filt_lane_R3: assert (lane < 3'(N_FILT));
    end

endmodule

// File: rtl/memevt_slot.sv
module memevt_slot
    import memevt_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_SRC = 7,
    parameter int ACC_W   = 8,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    wr_cnt,
    input  logic                    wr_cfg,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [N_FILT-1:0]       fevt_pulse,
    input  logic [N_FILT*SRC_W-1:0] fevt_src,
    input  logic [N_UNF-1:0]        uevt_pulse,
    input  logic [N_ACC*ACC_W-1:0]  acc_val,
    input  logic                    dram_tick,
    output logic [DATA_W-1:0]       cnt,
    output logic [CODE_W-1:0]       cfg_code,
    output logic [NUM_SRC-1:0]      cfg_mask,
    output logic                    ovf
);

    localparam int LANES = 2 ** LANE_W;
    localparam int SRCS  = 2 ** SRC_W;

    evt_cls_e                       cls;
    logic [LANE_W-1:0]              lane;
    logic [LANES-1:0]               fp_pad;
    logic [LANES-1:0][SRC_W-1:0]    src_pad;
    logic [LANES-1:0][ACC_W-1:0]    acc_pad;
    logic [SRCS-1:0]                mask_pad;
    logic [DATA_W-1:0]              inc;
    logic [DATA_W:0]                sum_ext;

    memevt_decode u_dec (
        .code (cfg_code),
        .cls  (cls),
        .lane (lane)
    );

    // Pad every lane group to a full power-of-two so any index is in range
    always_comb begin
        fp_pad   = '0;
        src_pad  = '0;
        acc_pad  = '0;
        mask_pad = '0;
        for (int i = 0; i < N_FILT; i++) begin
            fp_pad[i]  = fevt_pulse[i];
            src_pad[i] = fevt_src[i*SRC_W +: SRC_W];
        end
        for (int i = 0; i < N_ACC; i++)
            acc_pad[i] = acc_val[i*ACC_W +: ACC_W];
        mask_pad[NUM_SRC-1:0] = cfg_mask;
    end

    always_comb begin
        inc = '0;
        unique case (cls)
            CLS_FILT: inc = DATA_W'(fp_pad[lane] & mask_pad[src_pad[lane]]);
            CLS_UNF:  inc = DATA_W'(uevt_pulse[lane]);
            CLS_ACC:  inc = DATA_W'(acc_pad[lane]);
            CLS_CYC:  inc = DATA_W'(dram_tick);
            default:  inc = '0;
        endcase
    end

    assign sum_ext = {1'b0, cnt} + {1'b0, inc};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            ovf      <= 1'b0;
            cfg_code <= '0;
            cfg_mask <= '0;
        end else begin
            if (wr_cfg) begin
                cfg_code <= wdata[CODE_W-1:0];
                cfg_mask <= wdata[CODE_W +: NUM_SRC];
            end
            if (wr_cnt) begin
                cnt <= wdata;
                ovf <= 1'b0;
            end else if (en) begin
                cnt <= sum_ext[DATA_W-1:0];
                if (sum_ext[DATA_W])
                    ovf <= 1'b1;
            end
        end
    end

    // Idle or undefined code keeps the value (R2, R7)
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_NONE && !wr_cnt) |=> $stable(cnt));

    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_cnt) |=> $stable(cnt));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(wdata)) && !ovf);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wr_cnt) |=> ovf);

    assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_FILT && en && !wr_cnt) |=> ((cnt - $past(cnt)) <= 1));

    assert_tick_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_CYC && en && !wr_cnt && !dram_tick) |=> $stable(cnt));

endmodule

// File: rtl/memevt_regif.sv
module memevt_regif
    import memevt_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5,
    parameter int NUM_SRC = 7,
    localparam int IDX_W  = ADDR_W - 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic                    en,
    output logic [NUM_CTR-1:0]      wr_cnt,
    output logic [NUM_CTR-1:0]      wr_cfg,
    input  logic [DATA_W-1:0]       cnt      [NUM_CTR],
    input  logic [CODE_W-1:0]       cfg_code [NUM_CTR],
    input  logic [NUM_SRC-1:0]      cfg_mask [NUM_CTR],
    input  logic [NUM_CTR-1:0]      ovf
);

    localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(NUM_CTR * 4);

    logic [IDX_W-1:0] idx;
    logic [1:0]       fld;

    assign idx = reg_addr[ADDR_W-1:2];
    assign fld = reg_addr[1:0];

    always_comb begin
        for (int i = 0; i < NUM_CTR; i++) begin
            wr_cnt[i] = reg_wr && idx == IDX_W'(i) && fld == 2'd0;
            wr_cfg[i] = reg_wr && idx == IDX_W'(i) && fld == 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            en <= 1'b0;
        else if (reg_wr && reg_addr == EN_ADDR)
            en <= reg_wdata[0];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == EN_ADDR)
            reg_rdata = DATA_W'(en);
        for (int i = 0; i < NUM_CTR; i++) begin
            if (idx == IDX_W'(i)) begin
                unique case (fld)
                    2'd0:    reg_rdata = cnt[i];
                    2'd1:    reg_rdata = DATA_W'({cfg_mask[i], cfg_code[i]});
                    2'd2:    reg_rdata = DATA_W'(ovf[i]);
                    default: reg_rdata = '0;
                endcase
            end
        end
    end

    assert_en_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == EN_ADDR) |=> en == $past(reg_wdata[0]));

    assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_cnt, wr_cfg}) <= 1);

endmodule

// File: rtl/memevt_ctr_bank.sv
module memevt_ctr_bank
    import memevt_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 5,
    parameter int NUM_SRC = 7,
    parameter int ACC_W   = 8,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    input  logic [N_FILT-1:0]       fevt_pulse,
    input  logic [N_FILT*SRC_W-1:0] fevt_src,
    input  logic [N_UNF-1:0]        uevt_pulse,
    input  logic [N_ACC*ACC_W-1:0]  acc_val,
    input  logic                    dram_tick
);

    logic                  en;
    logic [NUM_CTR-1:0]    wr_cnt;
    logic [NUM_CTR-1:0]    wr_cfg;
    logic [NUM_CTR-1:0]    ovf;
    logic [DATA_W-1:0]     cnt      [NUM_CTR];
    logic [CODE_W-1:0]     cfg_code [NUM_CTR];
    logic [NUM_SRC-1:0]    cfg_mask [NUM_CTR];

    memevt_regif #(
        .NUM_CTR (NUM_CTR),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .NUM_SRC (NUM_SRC)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en        (en),
        .wr_cnt    (wr_cnt),
        .wr_cfg    (wr_cfg),
        .cnt       (cnt),
        .cfg_code  (cfg_code),
        .cfg_mask  (cfg_mask),
        .ovf       (ovf)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
        memevt_slot #(
            .DATA_W  (DATA_W),
            .NUM_SRC (NUM_SRC),
            .ACC_W   (ACC_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (en),
            .wr_cnt     (wr_cnt[g]),
            .wr_cfg     (wr_cfg[g]),
            .wdata      (reg_wdata),
            .fevt_pulse (fevt_pulse),
            .fevt_src   (fevt_src),
            .uevt_pulse (uevt_pulse),
            .acc_val    (acc_val),
            .dram_tick  (dram_tick),
            .cnt        (cnt[g]),
            .cfg_code   (cfg_code[g]),
            .cfg_mask   (cfg_mask[g]),
            .ovf        (ovf[g])
        );
    end

endmodule

// File: tb/test_memevt_ctr_bank.sv
module test_memevt_ctr_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [6:0]  fevt_pulse;
    logic [20:0] fevt_src;
    logic [7:0]  uevt_pulse;
    logic [47:0] acc_val;
    logic        dram_tick;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    memevt_ctr_bank i_memevt_ctr_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .fevt_pulse (fevt_pulse),
        .fevt_src   (fevt_src),
        .uevt_pulse (uevt_pulse),
        .acc_val    (acc_val),
        .dram_tick  (dram_tick)
    );

    // vector: code, mask, fpulse, src (all tags), upulse, acc (all lanes), tick, expected delta
    localparam int VW = 50;
    localparam int NV = 12;
    localparam logic [VW-1:0] VEC [NV] = '{
        {8'd1,   7'h01, 7'h01, 3'd0, 8'h00, 8'd0,   1'b0, 8'd1},   // R3 tag in mask
        {8'd1,   7'h02, 7'h01, 3'd0, 8'h00, 8'd0,   1'b0, 8'd0},   // R3 tag masked out
        {8'd7,   7'h7F, 7'h40, 3'd5, 8'h00, 8'd0,   1'b0, 8'd1},   // R3 last tagged event
        {8'd7,   7'h7F, 7'h20, 3'd5, 8'h00, 8'd0,   1'b0, 8'd0},   // R3 other strobe only
        {8'd16,  7'h00, 7'h00, 3'd0, 8'h01, 8'd0,   1'b0, 8'd1},   // R4 mask ignored
        {8'd97,  7'h00, 7'h00, 3'd0, 8'h80, 8'd0,   1'b0, 8'd1},   // R4 last plain event
        {8'd80,  7'h00, 7'h00, 3'd0, 8'h00, 8'd13,  1'b0, 8'd13},  // R5
        {8'd113, 7'h00, 7'h00, 3'd0, 8'h00, 8'd200, 1'b0, 8'd200}, // R5
        {8'd255, 7'h00, 7'h00, 3'd0, 8'h00, 8'd0,   1'b1, 8'd1},   // R6
        {8'd255, 7'h7F, 7'h7F, 3'd0, 8'hFF, 8'd9,   1'b0, 8'd0},   // R6 no tick
        {8'd0,   7'h7F, 7'h7F, 3'd0, 8'hFF, 8'd9,   1'b1, 8'd0},   // R2
        {8'd50,  7'h7F, 7'h7F, 3'd0, 8'hFF, 8'd9,   1'b1, 8'd0}    // R7
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdreg(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic stim(logic [6:0] fp, logic [20:0] src, logic [7:0] up,
                        logic [47:0] acc, logic tk, int cycles);
        @(negedge clk);
        fevt_pulse = fp; fevt_src = src; uevt_pulse = up; acc_val = acc; dram_tick = tk;
        repeat (cycles) @(negedge clk);
        fevt_pulse = '0; fevt_src = '0; uevt_pulse = '0; acc_val = '0; dram_tick = 1'b0;
    endtask

    function automatic logic [31:0] cfgw(logic [7:0] code, logic [6:0] mask);
        return {17'd0, mask, code};
    endfunction

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        fevt_pulse = '0; fevt_src = '0; uevt_pulse = '0; acc_val = '0; dram_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R10, R11)
        rdreg(5'd0, rd);  check("R10 reset count", rd, 0);
        rdreg(5'd1, rd);  check("R10 reset config", rd, 0);
        rdreg(5'd2, rd);  check("R10 reset overflow", rd, 0);
        rdreg(5'd24, rd); check("R10 reset enable", rd, 0);

        // Disabled: ticks ignored, writes land (R10)
        wr(5'd1, cfgw(8'd255, 7'h00));
        stim('0, '0, '0, '0, 1'b1, 3);
        rdreg(5'd0, rd); check("R10 frozen while disabled", rd, 0);
        wr(5'd0, 32'd9);
        rdreg(5'd0, rd); check("R10 write while disabled", rd, 9);
        wr(5'd24, 32'd1);
        rdreg(5'd24, rd); check("R11 enable readback", rd, 1);

        // Table walk on counter 0
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            e = VEC[v];
            wr(5'd1, cfgw(e[49:42], e[41:35]));
            wr(5'd0, 32'd0);
            stim(e[34:28], {7{e[27:25]}}, e[24:17], {6{e[16:9]}}, e[8], 1);
            rdreg(5'd0, rd);
            check($sformatf("R3-R7 vector %0d", v), rd, 32'(e[7:0]));
        end

        // Tag 7 is never in the mask (R3)
        wr(5'd1, cfgw(8'd2, 7'h7F));
        wr(5'd0, 32'd0);
        stim(7'h02, {7{3'd7}}, '0, '0, 1'b0, 1);
        rdreg(5'd0, rd); check("R3 tag seven", rd, 0);

        // Multi-cycle accumulate on lane 2 (R5)
        wr(5'd1, cfgw(8'd82, 7'h00));
        wr(5'd0, 32'd0);
        stim('0, '0, '0, {8'd15, 8'd14, 8'd13, 8'd12, 8'd11, 8'd10}, 1'b0, 3);
        rdreg(5'd0, rd); check("R5 lane 2 three cycles", rd, 36);

        // Wrap and sticky overflow (R8)
        wr(5'd1, cfgw(8'd255, 7'h00));
        wr(5'd0, 32'hFFFF_FFFF);
        stim('0, '0, '0, '0, 1'b1, 1);
        rdreg(5'd0, rd); check("R8 wrap to zero", rd, 0);
        rdreg(5'd2, rd); check("R8 overflow set", rd, 1);
        stim('0, '0, '0, '0, 1'b1, 1);
        rdreg(5'd2, rd); check("R8 overflow sticky", rd, 1);
        rdreg(5'd0, rd); check("R8 count after wrap", rd, 1);
        wr(5'd0, 32'd3);
        rdreg(5'd2, rd); check("R8 write clears overflow", rd, 0);

        // Write beats same-cycle increment (R9)
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd0; reg_wdata = 32'd100; dram_tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; dram_tick = 1'b0;
        rdreg(5'd0, rd); check("R9 write priority", rd, 100);

        // Independence of counters 0 and 3 (R1)
        wr(5'd13, cfgw(8'd255, 7'h00));
        wr(5'd12, 32'd0);
        wr(5'd1, cfgw(8'd1, 7'h7F));
        wr(5'd0, 32'd0);
        stim(7'h01, {7{3'd2}}, '0, '0, 1'b1, 1);
        stim('0, '0, '0, '0, 1'b1, 1);
        rdreg(5'd0, rd);  check("R1 counter 0", rd, 1);
        rdreg(5'd12, rd); check("R1 counter 3", rd, 2);
        rdreg(5'd13, rd); check("R11 config readback", rd, cfgw(8'd255, 7'h00));

        // Config write acts from the next cycle (R11)
        wr(5'd1, cfgw(8'd0, 7'h00));
        wr(5'd0, 32'd0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'd1; reg_wdata = cfgw(8'd255, 7'h00); dram_tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
        dram_tick = 1'b0;
        rdreg(5'd0, rd); check("R11 config takes effect next cycle", rd, 1);
        rdreg(5'd3, rd); check("R11 unmapped reads zero", rd, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule